// File: doc/BRIEF.md
# Clock Control Register with Usage Guard

This block is the main clock control register of a reset-and-clock unit. It keeps the enable bits, the ready flags and the divider settings for five clock sources: a high-speed internal RC (HI), a low-power internal RC (LP), a 48 MHz internal RC (R48), an external crystal or bypass source (EXT) and a PLL. Software reads and writes the whole word through a one-cycle write port. Hardware events change bits without software: power-mode entry and exit pulses, an external-clock failure, and stable or lock indications from the oscillator and PLL models.

Two inputs report how the clock tree is used right now: `sys_sel` names the system clock and `pll_ref` names the PLL reference. The register uses them to filter software writes, so no write can stop a clock that is still in use. When a hardware event and a software write hit the same bit in the same cycle, the hardware event takes effect. The `run_req` output tells the oscillator models which sources must keep running. A source runs when its main enable is set, and HI or LP also run when their Stop-mode keep bit is set. The `css_armed` output is the arm signal for the failure detector.

Top module: `clkctl_reg`

## Requirements
- R1: Register layout: bit0 HI enable, bit1 HI ready, bit2 HI Stop keep, bit5 divider-done flag, bit6 LP enable, bit7 LP ready, bit8 LP Stop keep, bit9 R48 enable, bit10 R48 ready, bit11 EXT enable, bit12 EXT ready, bit13 EXT bypass, bit14 EXT clock type, bit15 clock-security enable, bit16 PLL enable, bit17 PLL ready, bits 24 upward the HI divider (DIV_W bits). All other bits read 0. After reset only bit0 is 1, and `run_req` is 5'b00001.
- R2: `sys_sel` uses 0=HI, 1=LP, 2=EXT, 3=PLL. `pll_ref` uses 0=HI, 1=LP, 2=EXT, 3=none. A software write of 0 to the HI, LP or EXT enable is ignored while that source is the system clock, or while it is the PLL reference and the PLL enable is 1.
- R3: The HI enable is forced to 1 in three cases: a Stop exit pulse while `wake_sel_a` or `wake_sel_b` is 1, a Standby exit pulse, and `ext_fail` while `sys_sel` is EXT. This force overrides a software write of 0 in the same cycle. A Stop exit while both wake selects are 0 leaves the bit alone.
- R4: A write to the divider field is ignored, and the old value stays, while `pll_ref` is HI and the PLL enable is 1.
- R5: The divider-done flag goes to 0 on the edge that loads a new divider value. It goes back to 1 one cycle after `div_match` is seen high while the HI enable is 1. Writing the value the divider already holds leaves the flag alone.
- R6: The LP ready flag rises only when the LP main enable is set. The Stop keep bits change neither main enable. A keep bit sets the matching `run_req` bit (bit0 HI, bit1 LP).
- R7: A Stop or Standby entry pulse clears the R48, EXT and PLL enables on the next edge. It wins over a software write of 1 and over the usage guard.
- R8: Writes to the EXT bypass and clock type bits take effect only while the EXT enable is 0.
- R9: Software can only set the clock-security enable; a written 0 is ignored. The bit is cleared only by reset or by Standby entry. While it is set, `css_armed` rises one cycle after EXT ready is seen. It falls when `ext_fail` occurs and stays low until the enable is cleared.
- R10: A software write of 0 to the PLL enable is ignored while `sys_sel` is PLL.
- R11: Ready flags and the divider-done flag ignore software writes. Each ready flag equals, one cycle later, its stable or lock input ANDed with the matching main enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe, one cycle |
| wr_data | input | REG_W | Software write word |
| rd_data | output | REG_W | Register read value |
| sys_sel | input | 2 | Current system clock source |
| pll_ref | input | 2 | Current PLL reference source |
| stop_entry | input | 1 | Stop mode entry pulse |
| stop_exit | input | 1 | Stop mode exit pulse |
| standby_entry | input | 1 | Standby entry pulse |
| standby_exit | input | 1 | Standby exit pulse |
| wake_sel_a | input | 1 | First wake clock select |
| wake_sel_b | input | 1 | Second wake clock select |
| ext_fail | input | 1 | External clock failure event |
| hi_stable | input | 1 | HI oscillator stable |
| lp_stable | input | 1 | LP oscillator stable |
| r48_stable | input | 1 | R48 oscillator stable |
| ext_stable | input | 1 | EXT source stable |
| pll_lock | input | 1 | PLL locked |
| div_match | input | 1 | HI divided output matches setting |
| run_req | output | 5 | Run request per source (HI, LP, R48, EXT, PLL from bit0) |
| css_armed | output | 1 | Failure detector arm |

## Verification
The bench uses the default parameters: a 32-bit word and a 2-bit divider at bits 25:24, with the divider reset to 0. With these values a divider write can change the value (0 to 3) and can also repeat the held value, so both paths of the divider-done flag are reachable. Every usage-guard case is reached by driving `sys_sel` and `pll_ref` directly. The bench also covers the collisions where a power-mode event and a software write hit the same bit in the same cycle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int NSRC  = 5;
  localparam int S_HI  = 0;
  localparam int S_LP  = 1;
  localparam int S_R48 = 2;
  localparam int S_EXT = 3;
  localparam int S_PLL = 4;

  localparam int EN_BIT  [NSRC] = '{0, 6, 9, 11, 16};
  localparam int RDY_BIT [NSRC] = '{1, 7, 10, 12, 17};

  localparam int HI_KEEP_BIT = 2;
  localparam int DIV_OK_BIT  = 5;
  localparam int LP_KEEP_BIT = 8;
  localparam int BYP_BIT     = 13;
  localparam int TYPE_BIT    = 14;
  localparam int CSS_BIT     = 15;
  localparam int DIV_LSB     = 24;

  localparam logic [1:0] SYS_HI  = 2'd0;
  localparam logic [1:0] SYS_LP  = 2'd1;
  localparam logic [1:0] SYS_EXT = 2'd2;
  localparam logic [1:0] SYS_PLL = 2'd3;

  localparam logic [1:0] REF_HI   = 2'd0;
  localparam logic [1:0] REF_LP   = 2'd1;
  localparam logic [1:0] REF_EXT  = 2'd2;
endpackage

// File: rtl/clkctl_en_bit.sv
module clkctl_en_bit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_val,
  input  logic hold,
  input  logic hw_set,
  input  logic hw_clr,
  output logic q
);
  // priority: reset, hardware clear, hardware set, guarded software write
  always_ff @(posedge clk) begin
    if (rst)                       q <= RST_VAL;
    else if (hw_clr)               q <= 1'b0;
    else if (hw_set)               q <= 1'b1;
    else if (wr && (wr_val || !hold)) q <= wr_val;
  end
endmodule

// File: rtl/clkctl_div_track.sv
module clkctl_div_track #(
  parameter int               DIV_W   = 2,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             locked,
  input  logic             osc_en,
  input  logic             match,
  output logic [DIV_W-1:0] div,
  output logic             div_ok
);
  logic change;
  assign change = wr && !locked && (wr_div != div);

  always_ff @(posedge clk) begin
    if (rst) begin
      div    <= DIV_RST;
      div_ok <= 1'b0;
    end else if (change) begin
      div    <= wr_div;
      div_ok <= 1'b0;
    end else if (osc_en && match) begin
      div_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/clkctl_css.sv
module clkctl_css (
  input  logic clk,
  input  logic rst,
  input  logic css_en,
  input  logic ext_rdy,
  input  logic ext_fail,
  output logic armed
);
  logic tripped;

  always_ff @(posedge clk) begin
    if (rst || !css_en) begin
      armed   <= 1'b0;
      tripped <= 1'b0;
    end else if (armed && ext_fail) begin
      armed   <= 1'b0;
      tripped <= 1'b1;
    end else begin
      armed   <= ext_rdy && !tripped;
    end
  end
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
#(
  parameter int               REG_W   = 32,
  parameter int               DIV_W   = 2,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [1:0]       sys_sel,
  input  logic [1:0]       pll_ref,
  input  logic             stop_entry,
  input  logic             stop_exit,
  input  logic             standby_entry,
  input  logic             standby_exit,
  input  logic             wake_sel_a,
  input  logic             wake_sel_b,
  input  logic             ext_fail,
  input  logic             hi_stable,
  input  logic             lp_stable,
  input  logic             r48_stable,
  input  logic             ext_stable,
  input  logic             pll_lock,
  input  logic             div_match,
  output logic [4:0]       run_req,
  output logic             css_armed
);
  localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

  logic [NSRC-1:0] en_q, rdy_q, hold, hw_set, hw_clr, stable;
  logic            hi_keep, lp_keep, ext_byp, ext_type, css_en;
  logic [DIV_W-1:0] div_q;
  logic            div_ok;
  logic            pll_uses_hi, enter_low, wr_unused;

  assign wr_unused = ^wr_data;
  assign stable    = {pll_lock, ext_stable, r48_stable, lp_stable, hi_stable};
  assign enter_low = stop_entry || standby_entry;
  assign pll_uses_hi = en_q[S_PLL] && (pll_ref == REF_HI);

  // usage guard: which enables may not be cleared by software
  assign hold[S_HI]  = (sys_sel == SYS_HI)  || pll_uses_hi;
  assign hold[S_LP]  = (sys_sel == SYS_LP)  || (en_q[S_PLL] && pll_ref == REF_LP);
  assign hold[S_R48] = 1'b0;
  assign hold[S_EXT] = (sys_sel == SYS_EXT) || (en_q[S_PLL] && pll_ref == REF_EXT);
  assign hold[S_PLL] = (sys_sel == SYS_PLL);

  // hardware force events
  assign hw_set[S_HI]  = (stop_exit && (wake_sel_a || wake_sel_b)) || standby_exit
                       || (ext_fail && sys_sel == SYS_EXT);
  assign hw_set[S_LP]  = 1'b0;
  assign hw_set[S_R48] = 1'b0;
  assign hw_set[S_EXT] = 1'b0;
  assign hw_set[S_PLL] = 1'b0;
  assign hw_clr = {enter_low, enter_low, enter_low, 1'b0, 1'b0};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    clkctl_en_bit #(.RST_VAL(i == S_HI)) u_en (
      .clk   (clk),
      .rst   (rst),
      .wr    (wr_en),
      .wr_val(wr_data[EN_BIT[i]]),
      .hold  (hold[i]),
      .hw_set(hw_set[i]),
      .hw_clr(hw_clr[i]),
      .q     (en_q[i])
    );

    always_ff @(posedge clk) begin
      if (rst) rdy_q[i] <= 1'b0;
      else     rdy_q[i] <= en_q[i] && stable[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_keep  <= 1'b0;
      lp_keep  <= 1'b0;
      ext_byp  <= 1'b0;
      ext_type <= 1'b0;
    end else if (wr_en) begin
      hi_keep <= wr_data[HI_KEEP_BIT];
      lp_keep <= wr_data[LP_KEEP_BIT];
      if (!en_q[S_EXT]) begin
        ext_byp  <= wr_data[BYP_BIT];
        ext_type <= wr_data[TYPE_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || standby_entry)            css_en <= 1'b0;
    else if (wr_en && wr_data[CSS_BIT])  css_en <= 1'b1;
  end

  clkctl_div_track #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_en),
    .wr_div(wr_data[DIV_MSB:DIV_LSB]),
    .locked(pll_uses_hi),
    .osc_en(en_q[S_HI]),
    .match (div_match),
    .div   (div_q),
    .div_ok(div_ok)
  );

  clkctl_css u_css (
    .clk     (clk),
    .rst     (rst),
    .css_en  (css_en),
    .ext_rdy (rdy_q[S_EXT]),
    .ext_fail(ext_fail),
    .armed   (css_armed)
  );

  assign run_req = en_q | {3'b000, lp_keep, hi_keep};

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      rd_data[EN_BIT[i]]  = en_q[i];
      rd_data[RDY_BIT[i]] = rdy_q[i];
    end
    rd_data[HI_KEEP_BIT]     = hi_keep;
    rd_data[LP_KEEP_BIT]     = lp_keep;
    rd_data[DIV_OK_BIT]      = div_ok;
    rd_data[BYP_BIT]         = ext_byp;
    rd_data[TYPE_BIT]        = ext_type;
    rd_data[CSS_BIT]         = css_en;
    rd_data[DIV_MSB:DIV_LSB] = div_q;
  end
endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk #(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       sys_sel,
  input logic [1:0]       pll_ref,
  input logic             stop_entry,
  input logic             standby_entry,
  input logic             standby_exit,
  input logic             hi_en,
  input logic             lp_en,
  input logic             lp_rdy,
  input logic             r48_en,
  input logic             ext_en,
  input logic             ext_byp,
  input logic             ext_type,
  input logic             css_en,
  input logic             pll_en,
  input logic [DIV_W-1:0] div,
  input logic             div_ok
);
  logic enter;
  assign enter = stop_entry || standby_entry;

  assert_hi_guard_sys_R2: assert property (@(posedge clk) disable iff (rst)
    (sys_sel == 2'd0) |=> !$fell(hi_en));
  assert_hi_guard_pll_R2: assert property (@(posedge clk) disable iff (rst)
    (pll_ref == 2'd0 && pll_en) |=> !$fell(hi_en));
  assert_ext_guard_R2: assert property (@(posedge clk) disable iff (rst)
    (sys_sel == 2'd2 && !enter) |=> !$fell(ext_en));
  assert_standby_wake_R3: assert property (@(posedge clk) disable iff (rst)
    standby_exit |=> hi_en);
  assert_div_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (pll_ref == 2'd0 && pll_en) |=> $stable(div));
  assert_div_flag_drop_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(div) |-> !div_ok);
  assert_lp_rdy_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
    !lp_en |=> !lp_rdy);
  assert_entry_clears_R7: assert property (@(posedge clk) disable iff (rst)
    enter |=> !(r48_en || ext_en || pll_en));
  assert_ext_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    ext_en |=> $stable({ext_byp, ext_type}));
  assert_css_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !standby_entry |=> !$fell(css_en));
  assert_css_standby_R9: assert property (@(posedge clk) disable iff (rst)
    standby_entry |=> !css_en);
  assert_pll_guard_R10: assert property (@(posedge clk) disable iff (rst)
    (sys_sel == 2'd3 && !enter) |=> !$fell(pll_en));
endmodule

bind clkctl_reg clkctl_reg_chk #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sys_sel      (sys_sel),
  .pll_ref      (pll_ref),
  .stop_entry   (stop_entry),
  .standby_entry(standby_entry),
  .standby_exit (standby_exit),
  .hi_en        (rd_data[0]),
  .lp_en        (rd_data[6]),
  .lp_rdy       (rd_data[7]),
  .r48_en       (rd_data[9]),
  .ext_en       (rd_data[11]),
  .ext_byp      (rd_data[13]),
  .ext_type     (rd_data[14]),
  .css_en       (rd_data[15]),
  .pll_en       (rd_data[16]),
  .div          (rd_data[clkctl_pkg::DIV_LSB +: DIV_W]),
  .div_ok       (rd_data[5])
);

// File: tb/clkctl_reg_test.sv
`timescale 1ns/1ps
module clkctl_reg_test;
  localparam int B_HI = 0, B_HIRDY = 1, B_HIKEEP = 2, B_DIVOK = 5;
  localparam int B_LP = 6, B_LPRDY = 7, B_LPKEEP = 8;
  localparam int B_R48 = 9, B_R48RDY = 10, B_EXT = 11, B_EXTRDY = 12;
  localparam int B_BYP = 13, B_TYPE = 14, B_CSS = 15, B_PLL = 16, B_PLLRDY = 17;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [1:0] sys_sel = 2'd0, pll_ref = 2'd3;
  logic stop_entry = 0, stop_exit = 0, standby_entry = 0, standby_exit = 0;
  logic wake_sel_a = 0, wake_sel_b = 0, ext_fail = 0;
  logic hi_stable = 0, lp_stable = 0, r48_stable = 0, ext_stable = 0, pll_lock = 0, div_match = 0;
  logic [4:0] run_req;
  logic css_armed;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkctl_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sys_sel(sys_sel), .pll_ref(pll_ref), .stop_entry(stop_entry), .stop_exit(stop_exit),
    .standby_entry(standby_entry), .standby_exit(standby_exit),
    .wake_sel_a(wake_sel_a), .wake_sel_b(wake_sel_b), .ext_fail(ext_fail),
    .hi_stable(hi_stable), .lp_stable(lp_stable), .r48_stable(r48_stable),
    .ext_stable(ext_stable), .pll_lock(pll_lock), .div_match(div_match),
    .run_req(run_req), .css_armed(css_armed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic wset(input int b, input logic v);
    logic [31:0] d;
    d = rd_data; d[b] = v; wr(d);
  endtask

  task automatic wdiv(input logic [1:0] v);
    logic [31:0] d;
    d = rd_data; d[25:24] = v; wr(d);
  endtask

  task automatic t_reset();
    chk("R1 reset word", rd_data, 32'h1);
    chk("R1 reset run_req", {27'd0, run_req}, 32'h1);
  endtask

  task automatic t_ready();
    hi_stable = 1; step();
    chk("R11 hi ready follows", rd_data[B_HIRDY], 1);
    begin
      logic [31:0] d;
      d = rd_data; d[B_R48RDY] = 1; d[B_PLLRDY] = 1; wr(d);
    end
    step();
    chk("R11 ready ignores write", {rd_data[B_R48RDY], rd_data[B_PLLRDY]}, 0);
    r48_stable = 1; step();
    chk("R11 ready needs enable", rd_data[B_R48RDY], 0);
    wset(B_R48, 1);
    chk("R11 ready lags enable", rd_data[B_R48RDY], 0);
    step();
    chk("R11 ready after enable", rd_data[B_R48RDY], 1);
    r48_stable = 0; step();
    chk("R11 ready drops", rd_data[B_R48RDY], 0);
  endtask

  task automatic t_keep();
    lp_stable = 1;
    wset(B_LPKEEP, 1); step();
    chk("R6 keep leaves enable", rd_data[B_LP], 0);
    chk("R6 keep no ready", rd_data[B_LPRDY], 0);
    chk("R6 keep run_req", run_req[1], 1);
    wset(B_LP, 1); step();
    chk("R6 ready via enable", rd_data[B_LPRDY], 1);
    wset(B_LPKEEP, 0);
    chk("R6 keep clear leaves enable", rd_data[B_LP], 1);
  endtask

  task automatic t_protect();
    sys_sel = 2'd0; wset(B_HI, 0);
    chk("R2 hi held as sysclk", rd_data[B_HI], 1);
    sys_sel = 2'd1; wset(B_HI, 0);
    chk("R2 hi clear allowed", rd_data[B_HI], 0);
    wset(B_HI, 1);
    pll_ref = 2'd0; wset(B_PLL, 1);
    wset(B_HI, 0);
    chk("R2 hi held as pll ref", rd_data[B_HI], 1);
    wdiv(2'd2);
    chk("R4 divider locked", rd_data[25:24], 0);
    wset(B_PLL, 0);
    chk("R10 pll clear allowed", rd_data[B_PLL], 0);
    pll_ref = 2'd3;
    wset(B_EXT, 1);
    sys_sel = 2'd2; wset(B_EXT, 0);
    chk("R2 ext held as sysclk", rd_data[B_EXT], 1);
    sys_sel = 2'd1;
  endtask

  task automatic t_div();
    div_match = 1; step(); div_match = 0;
    chk("R5 flag set on match", rd_data[B_DIVOK], 1);
    wdiv(2'd3);
    chk("R5 new divider", rd_data[25:24], 3);
    chk("R5 flag drops", rd_data[B_DIVOK], 0);
    step();
    chk("R5 flag waits", rd_data[B_DIVOK], 0);
    div_match = 1; step(); div_match = 0;
    chk("R5 flag back", rd_data[B_DIVOK], 1);
    wdiv(2'd3);
    chk("R5 same value keeps flag", rd_data[B_DIVOK], 1);
    begin
      logic [31:0] d;
      d = rd_data; d[B_DIVOK] = 0; wr(d);
    end
    chk("R11 divider flag read-only", rd_data[B_DIVOK], 1);
  endtask

  task automatic t_ext_cfg();
    begin
      logic [31:0] d;
      d = rd_data; d[B_BYP] = 1; d[B_TYPE] = 1; wr(d);
    end
    chk("R8 cfg ignored while on", {rd_data[B_BYP], rd_data[B_TYPE]}, 0);
    wset(B_EXT, 0);
    begin
      logic [31:0] d;
      d = rd_data; d[B_BYP] = 1; d[B_TYPE] = 1; wr(d);
    end
    chk("R8 cfg taken while off", {rd_data[B_BYP], rd_data[B_TYPE]}, 3);
  endtask

  task automatic t_css();
    ext_stable = 1; wset(B_EXT, 1); step();
    chk("R11 ext ready", rd_data[B_EXTRDY], 1);
    wset(B_CSS, 1);
    chk("R9 css set", rd_data[B_CSS], 1);
    chk("R9 not yet armed", css_armed, 0);
    step();
    chk("R9 armed", css_armed, 1);
    wset(B_CSS, 0);
    chk("R9 css set-only", rd_data[B_CSS], 1);
    ext_fail = 1; step(); ext_fail = 0;
    chk("R9 disarm on fail", css_armed, 0);
    step();
    chk("R9 stays disarmed", css_armed, 0);
    standby_entry = 1; step(); standby_entry = 0;
    chk("R9 standby clears css", rd_data[B_CSS], 0);
    chk("R7 standby clears ext", rd_data[B_EXT], 0);
  endtask

  task automatic t_force();
    sys_sel = 2'd1;
    wset(B_HI, 0);
    stop_exit = 1; step(); stop_exit = 0;
    chk("R3 stop exit no wake", rd_data[B_HI], 0);
    wake_sel_b = 1; stop_exit = 1; step(); stop_exit = 0; wake_sel_b = 0;
    chk("R3 stop exit wake", rd_data[B_HI], 1);
    wset(B_HI, 0);
    standby_exit = 1; step(); standby_exit = 0;
    chk("R3 standby exit", rd_data[B_HI], 1);
    begin
      logic [31:0] d;
      d = rd_data; d[B_HI] = 0; standby_exit = 1; wr(d); standby_exit = 0;
    end
    chk("R3 force beats write", rd_data[B_HI], 1);
    wset(B_HI, 0);
    sys_sel = 2'd2; ext_fail = 1; step(); ext_fail = 0; sys_sel = 2'd1;
    chk("R3 ext failure", rd_data[B_HI], 1);
  endtask

  task automatic t_entry();
    begin
      logic [31:0] d;
      d = rd_data; d[B_R48] = 1; d[B_EXT] = 1; d[B_PLL] = 1;
      stop_entry = 1; wr(d); stop_entry = 0;
    end
    chk("R7 entry beats write", {rd_data[B_R48], rd_data[B_EXT], rd_data[B_PLL]}, 0);
    begin
      logic [31:0] d;
      d = rd_data; d[B_R48] = 1; d[B_EXT] = 1; d[B_PLL] = 1; wr(d);
    end
    chk("R7 enabled", {rd_data[B_R48], rd_data[B_EXT], rd_data[B_PLL]}, 3'b111);
    stop_entry = 1; step(); stop_entry = 0;
    chk("R7 stop clears", {rd_data[B_R48], rd_data[B_EXT], rd_data[B_PLL]}, 0);
    chk("R7 hi and lp kept", {rd_data[B_HI], rd_data[B_LP]}, 2'b11);
  endtask

  task automatic t_pll();
    pll_lock = 1; wset(B_PLL, 1); step();
    chk("R11 pll ready", rd_data[B_PLLRDY], 1);
    sys_sel = 2'd3; wset(B_PLL, 0);
    chk("R10 pll held as sysclk", rd_data[B_PLL], 1);
    stop_entry = 1; step(); stop_entry = 0;
    chk("R10 entry overrides guard", rd_data[B_PLL], 0);
    sys_sel = 2'd1;
  endtask

  initial begin
    repeat (4) step();
    rst = 0;
    t_reset();
    t_ready();
    t_keep();
    t_protect();
    t_div();
    t_ext_cfg();
    t_css();
    t_force();
    t_entry();
    t_pll();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule